// File: doc/BRIEF.md
# Guard-Bit Rounding Unit

This block shortens a significand that arrives with extra low-order guard bits down to its kept width. The kept field and the guard field come in on separate ports. A 2-bit mode input picks one of four ways to dispose of the guard bits:

- plain truncation;
- jamming, where any lost bit forces the kept LSB high;
- round half up;
- round to nearest, ties to even.

Before the decision is taken, the guard field is folded into three bits: the two highest dropped bits and a sticky bit. The sticky bit is the OR of every dropped bit below those two.

Beside the rounded field, the block reports two flags. One is a carry-out, raised when the increment overflows the kept field; it tells the surrounding datapath to renormalize. The other is an inexact flag. All three results are registered, so they appear one clock after the inputs. The default widths are a 24-bit kept field (single-precision significand with its hidden 1) and 8 guard bits. Exponent adjustment and exception handling are left to the surrounding datapath.

Top module: `rounding_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `keep_out`, `carry_out` and `inexact_out` are all cleared to 0 at that edge (synchronous reset).
- R2: Mode 2'b00 (truncate): `keep_out` equals `keep_in` and `carry_out` is 0, whatever the guard bits are.
- R3: Mode 2'b01 (jam): if any guard bit is 1, `keep_out` equals `keep_in` with bit 0 forced to 1; otherwise it equals `keep_in`. `carry_out` is always 0 in this mode.
- R4: Mode 2'b10 (half up): 1 is added to `keep_in` exactly when the top guard bit `guard_in[GUARD_W-1]` is 1.
- R5: Mode 2'b11 (nearest even), exact tie (guard equal to 1 followed by all zeros) with `keep_in[0]` = 0: `keep_in` is returned unchanged.
- R6: Mode 2'b11, exact tie with `keep_in[0]` = 1: 1 is added, so the result is even.
- R7: Mode 2'b11: a guard value above the tie always rounds up, and a guard value below the tie (top guard bit 0) never does.
- R8: Guard bits below the two highest affect the result only through their OR (sticky). Two guard patterns with equal top two bits and equal sticky give identical outputs in every mode.
- R9: `inexact_out` is 1 exactly when the guard field was nonzero, in every mode.
- R10: When an increment overflows an all-ones `keep_in`, `carry_out` is 1 and `keep_out` wraps to 0. `carry_out` is 0 in all other cases.
- R11: Outputs reflect the inputs present at the previous rising clock edge: exactly one cycle of latency when a new input arrives every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keep_in | input | KEEP_W | Kept significand bits before rounding |
| guard_in | input | GUARD_W | Dropped low-order bits; bit GUARD_W-1 is the most significant |
| mode_in | input | 2 | 00 truncate, 01 jam, 10 half up, 11 nearest even |
| keep_out | output | KEEP_W | Rounded kept field (registered) |
| carry_out | output | 1 | Increment overflowed the kept field (registered) |
| inexact_out | output | 1 | Some guard bit was nonzero (registered) |

## Verification
The hardest cases to reach are those that only narrow guard patterns expose. One is the exact tie in nearest-even mode, which random guard values hit once in 256 draws and with the needed LSB only half of those times. Another is an increment carried out of an all-ones kept field, which random 24-bit values practically never produce. The stimulus therefore drives directed ties and near-ties with both LSB values, all-ones kept fields in each rounding mode, and paired guard patterns that differ only below the top two bits. It then runs a random phase whose kept field is forced to all ones on a share of draws, and whose guard field is often replaced by a tie value.

// File: rtl/rounding_unit_pkg.sv
// Shared types for the guard-bit rounding unit.
// Assumes: the mode encoding below is fixed by the block's interface.
package rounding_unit_pkg;

    typedef enum logic [1:0] {
        RMODE_TRUNC   = 2'b00,
        RMODE_JAM     = 2'b01,
        RMODE_HALF_UP = 2'b10,
        RMODE_NEAR_EV = 2'b11
    } rmode_t;

    // Folded guard information: two top dropped bits and the sticky OR.
    typedef struct packed {
        logic hi;
        logic lo;
        logic sticky;
    } guard3_t;

endpackage

// File: rtl/guard_fold.sv
// Folds a guard field of any width into the top two dropped bits plus a
// sticky bit formed as the OR of all lower dropped bits.
// Assumes: GUARD_W >= 1; missing positions for narrow fields read as 0.
module guard_fold
    import rounding_unit_pkg::*;
#(
    parameter int GUARD_W = 8
) (
    input  logic [GUARD_W-1:0] guard_in,
    output guard3_t            fold_out,
    output logic               any_out
);

    // Width-dependent fold: the parameter selects the structure.
    generate
        if (GUARD_W >= 3) begin : g_wide
            always_comb begin
                // Pick top two bits and OR the remainder.
                fold_out.hi     = guard_in[GUARD_W-1];
                fold_out.lo     = guard_in[GUARD_W-2];
                fold_out.sticky = |guard_in[GUARD_W-3:0];
            end
        end else if (GUARD_W == 2) begin : g_two
            always_comb begin
                // Two guard bits, no sticky source.
                fold_out.hi     = guard_in[1];
                fold_out.lo     = guard_in[0];
                fold_out.sticky = 1'b0;
            end
        end else begin : g_one
            always_comb begin
                // Single guard bit.
                fold_out.hi     = guard_in[0];
                fold_out.lo     = 1'b0;
                fold_out.sticky = 1'b0;
            end
        end
    endgenerate

    // Inexact source: any dropped bit set, taken from the folded form.
    assign any_out = fold_out.hi | fold_out.lo | fold_out.sticky;

endmodule

// File: rtl/round_decide.sv
// Decides, from the mode, the kept LSB and the folded guard bits, whether
// to add one at the kept LSB or to jam the LSB high.
// Assumes: inc_out and jam_out are never both set.
module round_decide
    import rounding_unit_pkg::*;
(
    input  rmode_t  mode_in,
    input  logic    lsb_in,
    input  guard3_t fold_in,
    output logic    inc_out,
    output logic    jam_out
);

    logic below_half_nz;

    // Nonzero remainder under the top guard bit.
    assign below_half_nz = fold_in.lo | fold_in.sticky;

    // Per-mode rounding decision.
    always_comb begin
        inc_out = 1'b0;
        jam_out = 1'b0;
        unique case (mode_in)
            RMODE_TRUNC:   ;
            RMODE_JAM:     jam_out = fold_in.hi | below_half_nz;
            RMODE_HALF_UP: inc_out = fold_in.hi;
            RMODE_NEAR_EV: inc_out = fold_in.hi & (below_half_nz | lsb_in);
            default:       ;
        endcase
    end

endmodule

// File: rtl/lsb_incrementer.sv
// Adds a single bit at the LSB of a KEEP_W field, using a carry chain built
// by generate, and reports the carry out of the top bit.
// Assumes: KEEP_W >= 1.
module lsb_incrementer #(
    parameter int KEEP_W = 24
) (
    input  logic [KEEP_W-1:0] val_in,
    input  logic              inc_in,
    output logic [KEEP_W-1:0] sum_out,
    output logic              cout_out
);

    logic [KEEP_W:0] chain;

    assign chain[0] = inc_in;

    // One half-adder per kept bit.
    generate
        for (genvar i = 0; i < KEEP_W; i++) begin : g_bit
            assign sum_out[i]  = val_in[i] ^ chain[i];
            assign chain[i+1]  = val_in[i] & chain[i];
        end
    endgenerate

    assign cout_out = chain[KEEP_W];

endmodule

// File: rtl/rounding_unit.sv
// Guard-bit rounding unit: reduces a kept field plus guard bits to the kept
// width by truncation, jamming, half-up or nearest-even rounding, and
// registers the rounded field, carry-out and inexact flag.
// Assumes: GUARD_W >= 1, KEEP_W >= 1; one clock of latency.
module rounding_unit
    import rounding_unit_pkg::*;
#(
    parameter int KEEP_W  = 24,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEEP_W-1:0]  keep_in,
    input  logic [GUARD_W-1:0] guard_in,
    input  logic [1:0]         mode_in,
    output logic [KEEP_W-1:0]  keep_out,
    output logic               carry_out,
    output logic               inexact_out
);

    guard3_t           fold;
    logic              any_set;
    logic              do_inc;
    logic              do_jam;
    logic [KEEP_W-1:0] jammed;
    logic [KEEP_W-1:0] rounded;
    logic              ovf;

    guard_fold #(.GUARD_W(GUARD_W)) u_fold (
        .guard_in (guard_in),
        .fold_out (fold),
        .any_out  (any_set)
    );

    round_decide u_decide (
        .mode_in (rmode_t'(mode_in)),
        .lsb_in  (keep_in[0]),
        .fold_in (fold),
        .inc_out (do_inc),
        .jam_out (do_jam)
    );

    // Force the LSB high when jamming.
    always_comb begin
        jammed    = keep_in;
        jammed[0] = keep_in[0] | do_jam;
    end

    lsb_incrementer #(.KEEP_W(KEEP_W)) u_inc (
        .val_in   (jammed),
        .inc_in   (do_inc),
        .sum_out  (rounded),
        .cout_out (ovf)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_out    <= '0;
            carry_out   <= 1'b0;
            inexact_out <= 1'b0;
        end else begin
            keep_out    <= rounded;
            carry_out   <= ovf;
            inexact_out <= any_set;
        end
    end

endmodule

// File: rtl/rounding_unit_chk.sv
// Checker for rounding_unit: relates registered outputs to the inputs of
// the previous edge. Assumes one cycle latency; checks start one edge after
// reset release so $past never reaches into reset.
module rounding_unit_chk #(
    parameter int KEEP_W  = 24,
    parameter int GUARD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [KEEP_W-1:0]  keep_in,
    input logic [GUARD_W-1:0] guard_in,
    input logic [1:0]         mode_in,
    input logic [KEEP_W-1:0]  keep_out,
    input logic               carry_out,
    input logic               inexact_out
);

    logic primed;

    // Marks that the previous edge loaded the output register from inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (keep_out == '0 && !carry_out && !inexact_out));

    p_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_in) == 2'b00) |->
            (keep_out == $past(keep_in) && !carry_out));

    p_jam_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_in) == 2'b01 && $past(guard_in) != '0) |->
            (keep_out[0] && !carry_out));

    p_halfup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mode_in) == 2'b10 && $past(guard_in[GUARD_W-1])) |->
            (keep_out == $past(keep_in) + 1'b1));

    p_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (inexact_out == ($past(guard_in) != '0)));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (keep_out == '0));

    p_carry_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && carry_out) |-> ($past(keep_in) == '1));

endmodule

bind rounding_unit rounding_unit_chk #(.KEEP_W(KEEP_W), .GUARD_W(GUARD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .keep_in     (keep_in),
    .guard_in    (guard_in),
    .mode_in     (mode_in),
    .keep_out    (keep_out),
    .carry_out   (carry_out),
    .inexact_out (inexact_out)
);

// File: tb/tb_rounding_unit.sv
// Bench for rounding_unit: behavioural reference model with a queue of
// expected results, compared at every falling edge.
module tb_rounding_unit;

    localparam int KW = 24;
    localparam int GW = 8;
    localparam logic [GW-1:0] TIE = {1'b1, {(GW-1){1'b0}}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [KW-1:0] keep_in = '0;
    logic [GW-1:0] guard_in = '0;
    logic [1:0]    mode_in = 2'b00;
    logic [KW-1:0] keep_out;
    logic          carry_out;
    logic          inexact_out;

    int checks = 0;
    int errors = 0;

    logic [KW+1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    rounding_unit #(.KEEP_W(KW), .GUARD_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .keep_in(keep_in), .guard_in(guard_in),
        .mode_in(mode_in), .keep_out(keep_out), .carry_out(carry_out),
        .inexact_out(inexact_out)
    );

    // Reference: arithmetic on the guard value against the halfway point.
    function automatic logic [KW+1:0] model(logic [KW-1:0] k, logic [GW-1:0] g, logic [1:0] m);
        int unsigned gv   = int'(g);
        int unsigned half = int'(TIE);
        logic [KW:0] s;
        logic        up = 1'b0;
        logic [KW-1:0] kk = k;
        case (m)
            2'd1: if (gv != 0) kk[0] = 1'b1;
            2'd2: up = (gv >= half);
            2'd3: up = (gv > half) || (gv == half && k[0]);
            default: ;
        endcase
        s = {1'b0, kk} + (up ? 1 : 0);
        return {s[KW], (gv != 0), s[KW-1:0]};
    endfunction

    task automatic compare_front();
        logic [KW+1:0] e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({carry_out, inexact_out, keep_out} !== e) begin
            errors++;
            $display("FAIL %s: got carry=%b inexact=%b keep=%h, expected carry=%b inexact=%b keep=%h",
                     t, carry_out, inexact_out, keep_out, e[KW+1], e[KW], e[KW-1:0]);
        end
    endtask

    // One cycle: check the previous result, then drive the next vector.
    task automatic step(logic [KW-1:0] k, logic [GW-1:0] g, logic [1:0] m, string t);
        @(negedge clk);
        compare_front();
        keep_in  = k;
        guard_in = g;
        mode_in  = m;
        exp_q.push_back(model(k, g, m));
        tag_q.push_back(t);
    endtask

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset clears outputs despite busy inputs.
        keep_in = '1; guard_in = '1; mode_in = 2'b10;
        repeat (3) @(negedge clk);
        checks++;
        if ({carry_out, inexact_out, keep_out} !== '0) begin
            errors++;
            $display("FAIL R1: got %h, expected 0", {carry_out, inexact_out, keep_out});
        end
        rst_n = 1'b1;

        // R2: truncate ignores guard bits, even all-ones kept field.
        step(24'h123456, 8'hFF, 2'b00, "R2");
        step('1,         8'hFF, 2'b00, "R2");
        // R3: jam.
        step(24'h000010, 8'h01, 2'b01, "R3");
        step(24'h000010, 8'h00, 2'b01, "R3");
        step('1,         8'h80, 2'b01, "R3");
        // R4: half up.
        step(24'h000010, 8'h80, 2'b10, "R4");
        step(24'h000010, 8'h7F, 2'b10, "R4");
        // R5 / R6: ties.
        step(24'h000010, TIE,   2'b11, "R5");
        step(24'h000011, TIE,   2'b11, "R6");
        // R7: above and below tie.
        step(24'h000010, 8'h81, 2'b11, "R7");
        step(24'h000011, 8'h7F, 2'b11, "R7");
        // R8: same top bits and sticky, different low patterns.
        for (int m = 0; m < 4; m++) begin
            step(24'h000A0A, 8'h81, 2'(m), "R8");
            step(24'h000A0A, 8'h9F, 2'(m), "R8");
            step(24'h000A0B, 8'h42, 2'(m), "R8");
            step(24'h000A0B, 8'h44, 2'(m), "R8");
        end
        // R9: exact inputs in every mode.
        for (int m = 0; m < 4; m++) step(24'h00FFFF, 8'h00, 2'(m), "R9");
        // R10: wrap on overflow.
        step('1, 8'h80, 2'b10, "R10");
        step('1, TIE,   2'b11, "R10");
        step('1, 8'hC0, 2'b11, "R10");
        // R11: inputs change every cycle.
        step(24'h000001, 8'h80, 2'b10, "R11");
        step(24'h000002, 8'h00, 2'b00, "R11");
        step(24'h000003, 8'h01, 2'b01, "R11");

        // Random phase, biased to all-ones and ties.
        for (int i = 0; i < 3000; i++) begin
            logic [KW-1:0] k = KW'($urandom);
            logic [GW-1:0] g = GW'($urandom);
            logic [1:0]    m = 2'($urandom);
            if ($urandom_range(0, 7) == 0) k = '1;
            if ($urandom_range(0, 5) == 0) g = TIE;
            step(k, g, m, mode_tag(m));
        end

        // R1: reset in mid-stream clears outputs again.
        @(negedge clk);
        compare_front();
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if ({carry_out, inexact_out, keep_out} !== '0) begin
            errors++;
            $display("FAIL R1: got %h, expected 0", {carry_out, inexact_out, keep_out});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule